// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block generates two independent pulse-width modulated outputs from register settings. Software writes one shared control word that holds a ten-bit field group per channel, and one timing word per channel. Each timing word carries a duty count and a period count minus one. Each channel derives a count tick from the system clock through a prescaler. The prescaler uses a non-uniform table of divide ratios, has reserved codes, and offers a divide-by-one setting plus a bypass bit. A 16-bit up counter advances on each tick, and the output is in its active state from the start of each period until the counter reaches the duty count.

Timing words are double buffered. A write lands in a shadow copy and raises the channel's busy flag, which is readable in the control word. The shadow copy moves into the working registers at the next period boundary, or on the next clock when the channel is stopped, and the flag then clears. Writes that arrive while the flag is raised are discarded, so a period is never cut short by a half-applied update.

Each channel is a three-state machine. The states are OFF (stopped, counter cleared), RUN (counting) and STALL (enabled, but the prescaler code is reserved). The transitions are: start (OFF to RUN, when enable and gate are both set and the code is usable), stall (OFF or RUN to STALL, when both are set but the code is reserved and bypass is clear), resume (STALL to RUN, when the code becomes usable) and stop (any state to OFF, when enable or gate is cleared). Each transition is evaluated every clock.

Top module: `twin_pwm`

## Requirements
- R1: After reset, the control word and both timing words read as zero, and both outputs are high (the inactive level for the inverted polarity that a zero control word selects).
- R2: Register select 0 is the control word. Channel c's field group sits at bits 15c+9..15c. Within a group: bits 3:0 are the prescaler code, bit 4 enable, bit 5 polarity, bit 6 gate, bit 7 mode, bit 8 pulse and bit 9 bypass. Mode and pulse are stored and read back. Unused bits (14:10, 27:25, 31:30) read zero.
- R3: The prescaler divides the clock as follows. Codes 0..4 divide by 120/180/240/360/480, codes 8..12 by 12000/24000/36000/48000/72000, and code 15 by 1. When bypass is set, the divide is 1 whatever the code.
- R4: Register selects 1 and 2 are the timing words of channels 0 and 1, with the duty count D in bits 15:0 and the period count minus one P in bits 31:16. A period lasts P+1 ticks; the counter runs 0..P and wraps to 0. The output is active while the counter is below D: active for D ticks when D <= P, for the whole period when D > P, and never when D = 0.
- R5: Polarity bit 1 makes the active level high; polarity bit 0 makes it low.
- R6: A channel counts only when enable and gate are both set. Otherwise its output holds the inactive level and its counter is cleared.
- R7: With bypass clear and a reserved code (5..7, 13, 14), the counter holds and the output holds the inactive level.
- R8: A timing-word write sets busy bit 28+c. The value reads back at once, and it takes effect at the next period boundary (or on the next clock if the channel is stopped), at which point busy clears.
- R9: A timing-word write made while that channel's busy bit is set is discarded.
- R10: Writes to the busy bit positions have no effect on them; reads return the live busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register word select (byte offset divided by 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| pwm_out | output | 2 | PWM outputs, one per channel |

## Verification
Duty is measured by counting active samples over a whole number of periods, so the result does not depend on phase. It is tried with a duty of zero, a duty below the period, a duty equal to the period and a duty above it, which separates the cut-off comparison from the wrap point. Slow table codes against divide-by-one and bypass show whether the tick rate follows the code. Both polarities, and the stopped and stalled channels, show whether the idle level is the inverse of the active level. Back-to-back timing writes and running-versus-stopped updates show when the shadow copy is released and that a second write cannot overtake the first. Randomized period, duty, polarity and bypass settings on either channel then check that the channels do not disturb each other.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;

    localparam int DIV_W = 17;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_RUN   = 2'd1,
        CH_STALL = 2'd2
    } ch_state_t;

    // Field group of one channel, LSB first: code[3:0], en, pol, gate, mode, pulse, bypass
    typedef struct packed {
        logic       bypass;
        logic       pulse;
        logic       mode;
        logic       gate;
        logic       pol;
        logic       en;
        logic [3:0] code;
    } ch_cfg_t;

    // Divide ratio per prescaler code; zero marks a reserved code
    function automatic logic [DIV_W-1:0] div_ratio(input logic [3:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            4'd0:    r = 17'd120;
            4'd1:    r = 17'd180;
            4'd2:    r = 17'd240;
            4'd3:    r = 17'd360;
            4'd4:    r = 17'd480;
            4'd8:    r = 17'd12000;
            4'd9:    r = 17'd24000;
            4'd10:   r = 17'd36000;
            4'd11:   r = 17'd48000;
            4'd12:   r = 17'd72000;
            4'd15:   r = 17'd1;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/twin_pwm_presc.sv
module twin_pwm_presc
    import twin_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       bypass,
    input  logic [3:0] code,
    output logic       tick
);

    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] pcnt_q;

    assign ratio = bypass ? DIV_W'(1) : div_ratio(code);
    // >= keeps the divider from running away when the code shrinks mid-count
    assign tick  = run && (ratio != '0) && (pcnt_q >= ratio - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (!run || tick)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + DIV_W'(1);
    end

endmodule

// File: rtl/twin_pwm_chan.sv
module twin_pwm_chan
    import twin_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               gate,
    input  logic               pol,
    input  logic               bypass,
    input  logic [3:0]         code,
    input  logic               prd_we,
    input  logic [2*CNT_W-1:0] prd_wdata,
    output logic [2*CNT_W-1:0] prd_rdata,
    output logic               busy,
    output logic               pwm
);

    ch_state_t        state_q, state_d;
    logic             tick, boundary, run_req, code_ok, lvl;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_p1_q, act_dty_q, sh_p1_q, sh_dty_q;
    logic             busy_q;

    assign run_req  = en && gate;
    assign code_ok  = bypass || (div_ratio(code) != '0);
    assign boundary = tick && (cnt_q == act_p1_q);

    twin_pwm_presc u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == CH_RUN),
        .bypass (bypass),
        .code   (code),
        .tick   (tick)
    );

    // Next-state decision: stop, stall, start/resume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF, CH_RUN, CH_STALL: begin
                if (!run_req)      state_d = CH_OFF;
                else if (!code_ok) state_d = CH_STALL;
                else               state_d = CH_RUN;
            end
            default: state_d = CH_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (state_q == CH_OFF) cnt_q <= '0;
        else if (tick)             cnt_q <= boundary ? '0 : cnt_q + CNT_W'(1);
    end

    // Shadow timing word and busy flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_p1_q   <= '0;
            sh_dty_q  <= '0;
            act_p1_q  <= '0;
            act_dty_q <= '0;
            busy_q    <= 1'b0;
        end else if (prd_we && !busy_q) begin
            sh_p1_q  <= prd_wdata[2*CNT_W-1:CNT_W];
            sh_dty_q <= prd_wdata[CNT_W-1:0];
            busy_q   <= 1'b1;
        end else if (busy_q && (boundary || state_q == CH_OFF)) begin
            act_p1_q  <= sh_p1_q;
            act_dty_q <= sh_dty_q;
            busy_q    <= 1'b0;
        end
    end

    // Output process
    always_comb begin
        lvl = (state_q == CH_RUN) && (cnt_q < act_dty_q);
        pwm = pol ? lvl : !lvl;
    end

    assign busy      = busy_q;
    assign prd_rdata = {sh_p1_q, sh_dty_q};

    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= act_p1_q);

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STALL) |=> (state_q != CH_STALL) || $stable(cnt_q));

    assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(boundary || state_q == CH_OFF));

    assert_busy_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && prd_we && !boundary && state_q != CH_OFF) |=> $stable(sh_p1_q) && $stable(sh_dty_q));

endmodule

// File: rtl/twin_pwm.sv
module twin_pwm
    import twin_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [2*CNT_W-1:0] reg_wdata,
    output logic [2*CNT_W-1:0] reg_rdata,
    output logic [1:0]         pwm_out
);

    localparam int NUM_CH   = 2;
    localparam int REG_W    = 2 * CNT_W;
    localparam int STRIDE   = 15;
    localparam int FIELD_W  = $bits(ch_cfg_t);
    localparam int BUSY_LSB = 28;

    ch_cfg_t            cfg_q   [NUM_CH];
    logic [REG_W-1:0]   sh_word [NUM_CH];
    logic [NUM_CH-1:0]  busy;
    logic [NUM_CH-1:0]  prd_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) cfg_q[i] <= '0;
        end else if (reg_wr && reg_sel == 2'd0) begin
            for (int i = 0; i < NUM_CH; i++)
                cfg_q[i] <= ch_cfg_t'(reg_wdata[i*STRIDE +: FIELD_W]);
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == 2'd0) begin
            for (int i = 0; i < NUM_CH; i++) begin
                reg_rdata[i*STRIDE +: FIELD_W] = cfg_q[i];
                reg_rdata[BUSY_LSB + i]        = busy[i];
            end
        end else begin
            for (int i = 0; i < NUM_CH; i++)
                if (int'(reg_sel) == i + 1) reg_rdata = sh_word[i];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign prd_we[g] = reg_wr && (int'(reg_sel) == g + 1);

        twin_pwm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (cfg_q[g].en),
            .gate      (cfg_q[g].gate),
            .pol       (cfg_q[g].pol),
            .bypass    (cfg_q[g].bypass),
            .code      (cfg_q[g].code),
            .prd_we    (prd_we[g]),
            .prd_wdata (reg_wdata),
            .prd_rdata (sh_word[g]),
            .busy      (busy[g]),
            .pwm       (pwm_out[g])
        );

        assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!(cfg_q[g].en && cfg_q[g].gate) && $past(!(cfg_q[g].en && cfg_q[g].gate)))
            |-> (pwm_out[g] == !cfg_q[g].pol));

        assert_status_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_sel == 2'd0 && !busy[g]) |=> !busy[g]);
    end

endmodule

// File: tb/tb_twin_pwm.sv
`timescale 1ns/1ps
module tb_twin_pwm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twin_pwm dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic logic [31:0] fields(input bit en, input bit pol, input bit gate,
                                           input logic [3:0] code, input bit bypass);
        return {22'd0, bypass, 1'b0, 1'b0, gate, pol, en, code};
    endfunction

    function automatic int exp_ones(input int d, input int p1, input int dv,
                                    input int periods, input bit pol);
        int n, a, w;
        n = p1 + 1;
        a = ((d < n) ? d : n) * dv * periods;
        w = n * dv * periods;
        return pol ? a : (w - a);
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    task automatic wait_idle(input int ch);
        logic [31:0] v;
        bit ok = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            rd(2'd0, v);
            if (!v[28+ch]) begin ok = 1'b1; break; end
        end
        if (!ok) check("R8 busy never cleared", 1, 0);
    endtask

    task automatic measure(input int ch, input int cycles, output int ones);
        ones = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) ones++;
        end
    endtask

    task automatic run_case(input string tag, input int ch, input logic [3:0] code,
                            input bit bypass, input bit pol, input int p1, input int d,
                            input int dv, input int periods);
        int ones;
        wr(2'd0, fields(1'b1, pol, 1'b1, code, bypass) << (ch * 15));
        wr(2'(ch + 1), {16'(p1), 16'(d)});
        wait_idle(ch);
        repeat (3) @(negedge clk);
        measure(ch, (p1 + 1) * dv * periods, ones);
        check(tag, ones, exp_ones(d, p1, dv, periods, pol));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int ones;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, v); check("R1 control word", v, 0);
        rd(2'd1, v); check("R1 timing word ch0", v, 0);
        rd(2'd2, v); check("R1 timing word ch1", v, 0);
        check("R1 outputs", pwm_out, 2'b11);

        // R2 / R10: field layout, unused bits, read-only busy
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R2 R10 control readback", v, 32'h01FF_83FF);
        wr(2'd0, 32'h0000_0000);

        // R4: duty zero, below, equal to and above the period count
        run_case("R4 duty below period", 0, 4'd15, 1'b0, 1'b1, 4, 2, 1, 3);
        run_case("R4 duty zero", 0, 4'd15, 1'b0, 1'b1, 4, 0, 1, 3);
        run_case("R4 duty equal to period", 0, 4'd15, 1'b0, 1'b1, 4, 5, 1, 3);
        run_case("R4 duty above period", 0, 4'd15, 1'b0, 1'b1, 4, 9, 1, 3);

        // R5: inverted polarity
        run_case("R5 inverted polarity", 0, 4'd15, 1'b0, 1'b0, 4, 2, 1, 3);
        run_case("R5 inverted polarity ch1", 1, 4'd15, 1'b0, 1'b0, 6, 1, 1, 2);

        // R3: table codes and bypass
        run_case("R3 code 0 divide 120", 0, 4'd0, 1'b0, 1'b1, 2, 1, 120, 2);
        run_case("R3 code 1 divide 180", 1, 4'd1, 1'b0, 1'b1, 1, 1, 180, 2);
        run_case("R3 bypass over reserved code", 0, 4'd7, 1'b1, 1'b1, 3, 2, 1, 4);

        // R8: busy while channel runs, readback of shadow, release at boundary
        run_case("R8 base setting ch1", 1, 4'd15, 1'b0, 1'b1, 7, 3, 1, 2);
        wr(2'd2, {16'd3, 16'd1});
        rd(2'd0, v); check("R8 busy set after write", v[29], 1);
        rd(2'd2, v); check("R8 shadow readback", v, {16'd3, 16'd1});
        wait_idle(1);
        repeat (3) @(negedge clk);
        measure(1, 4 * 3, ones);
        check("R8 new timing applied", ones, exp_ones(1, 3, 1, 3, 1'b1));

        // R9: second write while busy is discarded
        wr(2'd2, {16'd1, 16'd1});
        wr(2'd2, {16'd7, 16'd7});
        wait_idle(1);
        rd(2'd2, v); check("R9 second write discarded", v, {16'd1, 16'd1});
        repeat (3) @(negedge clk);
        measure(1, 2 * 4, ones);
        check("R9 output follows first write", ones, exp_ones(1, 1, 1, 4, 1'b1));

        // R8: stopped channel releases on the next clock
        wr(2'd0, 32'd0);
        wr(2'd1, {16'd2, 16'd2});
        rd(2'd0, v); check("R8 busy set while stopped", v[28], 1);
        @(negedge clk);
        rd(2'd0, v); check("R8 busy cleared when stopped", v[28], 0);

        // R6: enable and gate both required
        wr(2'd0, fields(1'b1, 1'b1, 1'b0, 4'd15, 1'b0));
        repeat (2) @(negedge clk);
        measure(0, 100, ones); check("R6 gate clear holds inactive low", ones, 0);
        wr(2'd0, fields(1'b0, 1'b0, 1'b1, 4'd15, 1'b0));
        repeat (2) @(negedge clk);
        measure(0, 100, ones); check("R6 enable clear holds inactive high", ones, 100);

        // R7: reserved code stalls the channel
        wr(2'd0, fields(1'b1, 1'b1, 1'b1, 4'd5, 1'b0));
        repeat (2) @(negedge clk);
        measure(0, 100, ones); check("R7 reserved code 5 inactive", ones, 0);
        wr(2'd0, fields(1'b1, 1'b0, 1'b1, 4'd13, 1'b0));
        repeat (2) @(negedge clk);
        measure(0, 100, ones); check("R7 reserved code 13 inactive high", ones, 100);
        run_case("R7 recovery with valid code", 0, 4'd15, 1'b0, 1'b1, 2, 2, 1, 4);

        // Random settings across both channels (R4 R5 R3)
        for (int it = 0; it < 24; it++) begin
            int ch, p1, d;
            bit pol, byp;
            logic [3:0] code;
            ch   = int'($urandom % 2);
            p1   = int'($urandom % 8);
            d    = int'($urandom % 11);
            pol  = 1'($urandom % 2);
            byp  = 1'($urandom % 2);
            code = byp ? 4'($urandom % 16) : 4'd15;
            run_case("R4 R5 random setting", ch, code, byp, pol, p1, d, 1, 3);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule